// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a direct-mapped data cache placed between a processor load/store port and a backing memory that moves one word per handshake. With the default parameters it holds 16 KB of data: 1024 lines, each four 32-bit words wide. Each line keeps a tag, a valid bit and a dirty bit. A lookup hits when the indexed line is valid and its stored tag matches the tag of the address. A miss fetches the whole line from memory, one word at a time in ascending word order, before the access completes.

Stores are write-allocate and write-back. A store that misses first brings the line in, exactly as a load miss does. A store then updates only the cached word and marks the line dirty. Memory stays stale until that line is replaced. A dirty line that is displaced by a miss is written out in full, again in ascending word order, before the refill reads begin. A flush request walks every line and writes back each dirty one. This brings memory up to date before I/O. The lines stay valid and become clean.

Top module: `dc_wb_cache`

## Requirements
- R1: A byte address is decoded as tag = bits [31:14], line index = bits [13:4] and word-in-line = bits [3:2]. Bits [1:0] have no effect on which word is read or written.
- R2: Reset clears every valid and dirty bit. After reset, the first access to any line misses, and a flush writes nothing to memory. In reset the outputs cpu_ready, mem_req and flush_done are 0.
- R3: An access whose indexed line is valid with a matching tag completes with no memory request, and a load returns the addressed word.
- R4: A load miss on a clean or empty line issues exactly four memory reads (mem_we = 0) to the requested line, in word order 0, 1, 2, 3. It then installs the tag and returns the addressed word.
- R5: A store miss performs the same line fetch as a load miss and then writes the word into the cache. A later load of that word returns the stored value with no memory traffic.
- R6: A store hit changes only the cached word, issues no memory write, and marks the line dirty.
- R7: A miss on a valid dirty line first issues four memory writes (mem_we = 1) of the old line to its old address, in word order 0..3. Only then does it issue the four refill reads.
- R8: A miss on a valid clean line issues no memory writes.
- R9: A flush writes back all four words of every dirty line and then pulses flush_done. Afterwards the lines are clean, so a second flush writes nothing, and they remain valid, so later loads of them hit.
- R10: cpu_ready is a single-cycle pulse per request. mem_req, mem_addr, mem_we and mem_wdata hold steady from the cycle a memory request is raised until the cycle mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid while cpu_ready is 1 |
| flush_req | input | 1 | Request to write back all dirty lines, held until flush_done |
| flush_done | output | 1 | One-cycle pulse when the flush has finished |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned byte address for memory |
| mem_wdata | output | 32 | Write data for memory |
| mem_ack | input | 1 | Memory acknowledge, one cycle per word |
| mem_rdata | input | 32 | Read data from memory, valid with mem_ack |

## Verification
The hardest situation to reach is a dirty line being displaced. The stimulus has to make a line valid, store into it, and then touch a second address with the same index and a different tag. The stimulus table does this twice: once with a load and once with a store that misses. For each operation the bench logs the memory traffic and checks the write count, the read count and the exact order of addresses. Flush is reached after several lines are left dirty. The bench then compares its whole backing memory against a reference image. A reset taken while a line is dirty shows that the dirty state is dropped rather than written back.

// File: rtl/dc_pkg.sv
package dc_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_LOOKUP,
      S_WBACK,
      S_FILL,
      S_SCAN,
      S_FDONE
   } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
   parameter int LINES = 1024,
   parameter int TAG_W = 18,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] idx,
   output logic             rd_valid,
   output logic             rd_dirty,
   output logic [TAG_W-1:0] rd_tag,
   input  logic             fill_en,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             set_dirty,
   input  logic             clr_dirty
);
   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else begin
         if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
         end
         if (set_dirty) dirty_q[idx] <= 1'b1;
         if (clr_dirty) dirty_q[idx] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) tag_q[idx] <= fill_tag;
   end

   assign rd_valid = valid_q[idx];
   assign rd_dirty = dirty_q[idx];
   assign rd_tag   = tag_q[idx];

   // R6: only a resident line may be marked dirty
   assert_dirty_on_valid_R6: assert property (@(posedge clk) disable iff (rst)
      set_dirty |-> valid_q[idx]);
   // R6: dirty state never outlives a line's validity
   assert_dirty_subset_R6: assert property (@(posedge clk) disable iff (rst)
      (dirty_q & ~valid_q) == '0);
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
   parameter int LINES      = 1024,
   parameter int LINE_WORDS = 4,
   parameter int WORD_W     = 32,
   localparam int IDX_W  = $clog2(LINES),
   localparam int WSEL_W = $clog2(LINE_WORDS)
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WSEL_W-1:0] word,
   output logic [WORD_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data
);
   logic [WORD_W-1:0] lane_rd [LINE_WORDS];

   for (genvar g = 0; g < LINE_WORDS; g++) begin : g_lane
      logic [WORD_W-1:0] mem_q [LINES];
      always_ff @(posedge clk) begin
         if (wr_en && word == WSEL_W'(g)) mem_q[idx] <= wr_data;
      end
      assign lane_rd[g] = mem_q[idx];
   end

   assign rd_data = lane_rd[word];
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
   import dc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 32,
   parameter int IDX_W  = 10,
   parameter int WSEL_W = 2,
   parameter int TAG_W  = 18,
   localparam int BOFS_W = ADDR_W - TAG_W - IDX_W - WSEL_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   input  logic              flush_req,
   output logic              flush_done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [IDX_W-1:0]  ts_idx,
   input  logic              ts_valid,
   input  logic              ts_dirty,
   input  logic [TAG_W-1:0]  ts_tag,
   output logic              ts_fill,
   output logic [TAG_W-1:0]  ts_fill_tag,
   output logic              ts_set_dirty,
   output logic              ts_clr_dirty,
   output logic [WSEL_W-1:0] ds_word,
   input  logic [WORD_W-1:0] ds_rdata,
   output logic              ds_wr_en,
   output logic [WORD_W-1:0] ds_wdata
);
   dc_state_e state_q, state_d;
   logic [TAG_W-1:0]  req_tag_q;
   logic [IDX_W-1:0]  req_idx_q;
   logic [WSEL_W-1:0] req_word_q;
   logic              req_we_q;
   logic [WORD_W-1:0] req_wdata_q;
   logic [IDX_W-1:0]  scan_q;
   logic [WSEL_W-1:0] cnt_q;
   logic              flushing_q;
   logic              unused_lo;

   assign unused_lo = ^cpu_addr[BOFS_W-1:0];

   wire [IDX_W-1:0] cur_idx   = flushing_q ? scan_q : req_idx_q;
   wire             last_word = &cnt_q;
   wire             hit       = ts_valid && (ts_tag == req_tag_q);

   assign ts_idx      = cur_idx;
   assign ts_fill_tag = req_tag_q;

   always_comb begin
      state_d      = state_q;
      cpu_ready    = 1'b0;
      flush_done   = 1'b0;
      mem_req      = 1'b0;
      mem_we       = 1'b0;
      mem_addr     = '0;
      mem_wdata    = ds_rdata;
      ts_fill      = 1'b0;
      ts_set_dirty = 1'b0;
      ts_clr_dirty = 1'b0;
      ds_word      = req_word_q;
      ds_wr_en     = 1'b0;
      ds_wdata     = req_wdata_q;
      case (state_q)
         S_IDLE: begin
            if (cpu_req)        state_d = S_LOOKUP;
            else if (flush_req) state_d = S_SCAN;
         end
         S_LOOKUP: begin
            if (hit) begin
               cpu_ready = 1'b1;
               if (req_we_q) begin
                  ds_wr_en     = 1'b1;
                  ts_set_dirty = 1'b1;
               end
               state_d = S_IDLE;
            end else if (ts_valid && ts_dirty) begin
               state_d = S_WBACK;
            end else begin
               state_d = S_FILL;
            end
         end
         S_WBACK: begin
            ds_word  = cnt_q;
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = {ts_tag, cur_idx, cnt_q, {BOFS_W{1'b0}}};
            if (mem_ack && last_word) begin
               if (flushing_q) begin
                  ts_clr_dirty = 1'b1;
                  state_d      = S_SCAN;
               end else begin
                  state_d = S_FILL;
               end
            end
         end
         S_FILL: begin
            mem_req  = 1'b1;
            mem_addr = {req_tag_q, req_idx_q, cnt_q, {BOFS_W{1'b0}}};
            if (mem_ack) begin
               ds_word  = cnt_q;
               ds_wdata = mem_rdata;
               ds_wr_en = 1'b1;
               if (last_word) begin
                  ts_fill = 1'b1;
                  state_d = S_LOOKUP;
               end
            end
         end
         S_SCAN: begin
            if (ts_valid && ts_dirty) state_d = S_WBACK;
            else if (&scan_q)         state_d = S_FDONE;
         end
         S_FDONE: begin
            flush_done = 1'b1;
            state_d    = S_IDLE;
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= S_IDLE;
         req_tag_q   <= '0;
         req_idx_q   <= '0;
         req_word_q  <= '0;
         req_we_q    <= 1'b0;
         req_wdata_q <= '0;
         scan_q      <= '0;
         cnt_q       <= '0;
         flushing_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == S_IDLE && cpu_req) begin
            req_tag_q   <= cpu_addr[ADDR_W-1 -: TAG_W];
            req_idx_q   <= cpu_addr[BOFS_W+WSEL_W +: IDX_W];
            req_word_q  <= cpu_addr[BOFS_W +: WSEL_W];
            req_we_q    <= cpu_we;
            req_wdata_q <= cpu_wdata;
         end else if (state_q == S_IDLE && flush_req) begin
            scan_q     <= '0;
            flushing_q <= 1'b1;
         end
         if ((state_q == S_WBACK || state_q == S_FILL) && mem_ack)
            cnt_q <= cnt_q + WSEL_W'(1);
         if (state_q == S_SCAN && !(ts_valid && ts_dirty) && !(&scan_q))
            scan_q <= scan_q + IDX_W'(1);
         if (state_q == S_FDONE) flushing_q <= 1'b0;
      end
   end

   wire [WSEL_W-1:0] addr_word = mem_addr[BOFS_W +: WSEL_W];

   // R10: request fields held until acknowledged
   assert_mem_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && (!mem_we || $stable(mem_wdata))));
   // R10: completion is a one-cycle pulse
   assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (rst)
      cpu_ready |=> !cpu_ready);
   // R3: a completing access has no memory request outstanding
   assert_hit_quiet_R3: assert property (@(posedge clk) disable iff (rst)
      cpu_ready |-> !mem_req);
   // R4: refill words go out in ascending order
   assert_fill_ascending_R4: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_we && mem_ack && !(&addr_word))
      |=> (mem_req && !mem_we && addr_word == $past(addr_word) + WSEL_W'(1)));
   // R7: victim write-back of a miss is followed straight by the refill
   assert_wb_then_fill_R7: assert property (@(posedge clk) disable iff (rst)
      (state_q == S_WBACK && mem_ack && last_word && !flushing_q)
      |=> (mem_req && !mem_we));
endmodule

// File: rtl/dc_wb_cache.sv
module dc_wb_cache #(
   parameter int ADDR_W     = 32,
   parameter int WORD_W     = 32,
   parameter int LINES      = 1024,
   parameter int LINE_WORDS = 4,
   localparam int BOFS_W = $clog2(WORD_W / 8),
   localparam int WSEL_W = $clog2(LINE_WORDS),
   localparam int IDX_W  = $clog2(LINES),
   localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - BOFS_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [WORD_W-1:0] cpu_rdata,
   input  logic              flush_req,
   output logic              flush_done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata
);
   initial begin
      assert_lines_pow2: assert ((1 << IDX_W) == LINES)
         else $error("LINES must be a power of two");
      assert_words_pow2: assert (LINE_WORDS >= 2 && (1 << WSEL_W) == LINE_WORDS)
         else $error("LINE_WORDS must be a power of two, at least 2");
      assert_word_bytes: assert (WORD_W >= 16 && WORD_W % 8 == 0 && (8 << BOFS_W) == WORD_W)
         else $error("WORD_W must be a power-of-two byte count of at least 2");
      assert_tag_room: assert (TAG_W > 0)
         else $error("address too narrow for the geometry");
   end

   logic [IDX_W-1:0]  ts_idx;
   logic              ts_valid, ts_dirty, ts_fill, ts_set_dirty, ts_clr_dirty;
   logic [TAG_W-1:0]  ts_tag, ts_fill_tag;
   logic [WSEL_W-1:0] ds_word;
   logic [WORD_W-1:0] ds_rdata, ds_wdata;
   logic              ds_wr_en;

   dc_ctrl #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W), .TAG_W(TAG_W)
   ) u_ctrl (
      .clk(clk), .rst(rst),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .flush_req(flush_req), .flush_done(flush_done),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .ts_idx(ts_idx), .ts_valid(ts_valid), .ts_dirty(ts_dirty), .ts_tag(ts_tag),
      .ts_fill(ts_fill), .ts_fill_tag(ts_fill_tag),
      .ts_set_dirty(ts_set_dirty), .ts_clr_dirty(ts_clr_dirty),
      .ds_word(ds_word), .ds_rdata(ds_rdata), .ds_wr_en(ds_wr_en), .ds_wdata(ds_wdata)
   );

   dc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst(rst), .idx(ts_idx),
      .rd_valid(ts_valid), .rd_dirty(ts_dirty), .rd_tag(ts_tag),
      .fill_en(ts_fill), .fill_tag(ts_fill_tag),
      .set_dirty(ts_set_dirty), .clr_dirty(ts_clr_dirty)
   );

   dc_data_store #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) u_data (
      .clk(clk), .idx(ts_idx), .word(ds_word), .rd_data(ds_rdata),
      .wr_en(ds_wr_en), .wr_data(ds_wdata)
   );

   assign cpu_rdata = ds_rdata;
endmodule

// File: tb/dc_wb_cache_test.sv
`timescale 1ns/1ps
module dc_wb_cache_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic        cpu_ready;
   logic [31:0] cpu_rdata;
   logic        flush_req = 1'b0, flush_done;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #4 clk = ~clk;

   dc_wb_cache uut (
      .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .flush_req(flush_req), .flush_done(flush_done), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int checks = 0, errors = 0;
   bit done = 0;
   logic [31:0] bmem [1024];   // backing memory
   logic [31:0] refm [1024];   // processor-visible reference
   logic [31:0] log_a [16];
   logic        log_w [16];
   int          nlog = 0, nrd = 0, nwr = 0;

   typedef struct packed {
      logic [1:0]  tg;
      logic [5:0]  ix;
      logic [1:0]  wd;
      logic [1:0]  lo;
      logic        we;
      logic [31:0] dat;
      logic [2:0]  erd;
      logic [2:0]  ewr;
   } vec_t;

   localparam vec_t VEC [13] = '{
      '{2'd0, 6'd1,  2'd1, 2'd0, 1'b0, 32'h0,        3'd4, 3'd0},
      '{2'd0, 6'd1,  2'd3, 2'd0, 1'b0, 32'h0,        3'd0, 3'd0},
      '{2'd0, 6'd1,  2'd0, 2'd3, 1'b0, 32'h0,        3'd0, 3'd0},
      '{2'd0, 6'd1,  2'd2, 2'd0, 1'b1, 32'hDEADBEEF, 3'd0, 3'd0},
      '{2'd0, 6'd1,  2'd2, 2'd1, 1'b0, 32'h0,        3'd0, 3'd0},
      '{2'd1, 6'd1,  2'd0, 2'd0, 1'b0, 32'h0,        3'd4, 3'd4},
      '{2'd0, 6'd1,  2'd2, 2'd0, 1'b0, 32'h0,        3'd4, 3'd0},
      '{2'd2, 6'd5,  2'd3, 2'd0, 1'b1, 32'h12345678, 3'd4, 3'd0},
      '{2'd2, 6'd5,  2'd3, 2'd0, 1'b0, 32'h0,        3'd0, 3'd0},
      '{2'd3, 6'd5,  2'd0, 2'd2, 1'b1, 32'hCAFEF00D, 3'd4, 3'd4},
      '{2'd1, 6'd63, 2'd1, 2'd0, 1'b1, 32'h0BADC0DE, 3'd4, 3'd0},
      '{2'd1, 6'd63, 2'd1, 2'd0, 1'b1, 32'h55AA33CC, 3'd0, 3'd0},
      '{2'd0, 6'd2,  2'd0, 2'd0, 1'b0, 32'h0,        3'd4, 3'd0}
   };
   string lbl [13] = '{"R2 R4", "R3", "R1 R3", "R6", "R1 R6", "R7", "R8 R7",
                       "R5", "R5", "R7 R5", "R5", "R6", "R4"};

   function automatic logic [31:0] mk_addr(logic [1:0] tg, logic [5:0] ix, logic [1:0] wd, logic [1:0] lo);
      return {16'h0, tg, 4'h0, ix, wd, lo};
   endfunction
   function automatic int key(logic [31:0] a);
      return int'({a[15:14], a[9:4], a[3:2]});
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // memory responder: one acknowledged word every two cycles
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req && !mem_ack) begin
            if (mem_we) begin bmem[key(mem_addr)] = mem_wdata; nwr++; end
            else begin mem_rdata = bmem[key(mem_addr)]; nrd++; end
            if (nlog < 16) begin log_a[nlog] = mem_addr; log_w[nlog] = mem_we; end
            nlog++;
            mem_ack = 1'b1;
         end else begin
            mem_ack = 1'b0;
         end
      end
   end

   task automatic cpu_op(input logic we, input logic [31:0] a, input logic [31:0] d,
                         output logic [31:0] rd);
      nlog = 0; nrd = 0; nwr = 0;
      cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_req = 1'b1;
      do @(negedge clk); while (!cpu_ready);
      rd = cpu_rdata;
      cpu_req = 1'b0;
      @(negedge clk);
      chk(cpu_ready == 1'b0, "R10 ready pulse", {31'h0, cpu_ready}, 32'h0);
   endtask

   task automatic do_flush();
      nlog = 0; nrd = 0; nwr = 0;
      flush_req = 1'b1;
      do @(negedge clk); while (!flush_done);
      flush_req = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] a, rd, saved;
      bit ok;
      int bad;
      for (int i = 0; i < 1024; i++) begin
         bmem[i] = 32'h1000_0000 ^ (i * 32'h0000_9E37);
         refm[i] = bmem[i];
      end
      repeat (3) @(negedge clk);
      chk(!cpu_ready && !mem_req && !flush_done, "R2 reset outputs",
          {29'h0, cpu_ready, mem_req, flush_done}, 32'h0);
      rst = 1'b0;
      @(negedge clk);

      for (int v = 0; v < 13; v++) begin
         a = mk_addr(VEC[v].tg, VEC[v].ix, VEC[v].wd, VEC[v].lo);
         cpu_op(VEC[v].we, a, VEC[v].dat, rd);
         if (VEC[v].we) refm[key(a)] = VEC[v].dat;
         else chk(rd == refm[key(a)], {lbl[v], " load data"}, rd, refm[key(a)]);
         chk(nrd == int'(VEC[v].erd) && nwr == int'(VEC[v].ewr), {lbl[v], " traffic rd/wr"},
             {nrd[15:0], nwr[15:0]}, {13'h0, VEC[v].erd, 13'h0, VEC[v].ewr});
         // R4 R7: writes of the old line first, then reads of the new line, word order 0..3
         ok = (nlog == int'(VEC[v].erd) + int'(VEC[v].ewr));
         for (int k = 0; k < nlog && k < 16; k++) begin
            if (k < int'(VEC[v].ewr))
               ok &= log_w[k] && log_a[k][3:2] == k[1:0] && log_a[k][13:4] == a[13:4]
                     && log_a[k][1:0] == 2'b00;
            else
               ok &= !log_w[k] && log_a[k] == {a[31:4], k[1:0] - VEC[v].ewr[1:0], 2'b00};
         end
         chk(ok, {lbl[v], " burst order"}, nlog, VEC[v].erd + VEC[v].ewr);
      end

      // R9: flush writes dirty lines (index 5 and index 63) and memory matches reference
      do_flush();
      chk(nwr == 8 && nrd == 0, "R9 flush traffic", {nrd[15:0], nwr[15:0]}, 32'h0000_0008);
      bad = 0;
      for (int i = 0; i < 1024; i++) if (bmem[i] !== refm[i]) bad++;
      chk(bad == 0, "R9 memory image after flush", bad, 0);
      a = mk_addr(2'd1, 6'd63, 2'd1, 2'd0);
      cpu_op(1'b0, a, 32'h0, rd);
      chk(rd == 32'h55AA33CC && nlog == 0, "R9 line stays valid", rd, 32'h55AA33CC);
      do_flush();
      chk(nwr == 0, "R9 second flush writes nothing", nwr, 0);

      // R2: dirty state dropped by reset
      a = mk_addr(2'd0, 6'd2, 2'd1, 2'd0);
      saved = bmem[key(a)];
      cpu_op(1'b1, a, 32'h7777_7777, rd);
      chk(nlog == 0, "R6 store hit no traffic", nlog, 0);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk(!cpu_ready && !mem_req && !flush_done, "R2 outputs in reset",
          {29'h0, cpu_ready, mem_req, flush_done}, 32'h0);
      rst = 1'b0;
      @(negedge clk);
      do_flush();
      chk(nwr == 0, "R2 flush after reset", nwr, 0);
      cpu_op(1'b0, a, 32'h0, rd);
      chk(nrd == 4 && nwr == 0, "R2 miss after reset", {nrd[15:0], nwr[15:0]}, 32'h0004_0000);
      chk(rd == saved, "R2 data from memory", rd, saved);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule